// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. Once per comparison cycle it looks at the raising and lowering pulses that a phase-frequency detector produces. It measures how long those pulses were active by counting ticks of a fast sampling clock, and it turns the result into one active-high lock flag.

Lock uses hysteresis. A cycle counts as good when its error is below an acquire threshold. A cycle counts as bad when its error is above a larger release threshold. The flag rises only after a run of consecutive good cycles. A precision input sets that run to three or five cycles. Once the flag is high, it stays high until a single bad cycle appears. The comparison-cycle strobe comes from the reference divider. Either the chip-enable pin or a software power-down bit clears the detector.

The thresholds are parameters in sampling-clock ticks. With a 1 ns sampling clock the defaults of 15 and 25 ticks stand for 15 ns and 25 ns.

Top module: `lock_watch`

## Requirements
- R1: The phase error of a cycle is the number of sampling-clock edges at which upPulse or dnPulse was high. The window runs from the edge after the previous cycleStrobe up to and including the edge on which cycleStrobe is high. The count saturates at 2^ERR_BITS-1 (255 by default) and never wraps.
- R2: With precisionSel = 0, lockFlag rises at the clock edge after the strobe that closes the third consecutive good cycle. A good cycle has an error strictly less than GOOD_TICKS (default 15).
- R3: With precisionSel = 1, five consecutive good cycles are needed before lockFlag rises.
- R4: While lockFlag is high, a cycle whose error is strictly greater than BAD_TICKS (default 25) clears lockFlag at the next clock edge.
- R5: While lockFlag is high, a cycle whose error is at most BAD_TICKS leaves lockFlag high. This includes errors between the two thresholds.
- R6: While lockFlag is low, a cycle whose error is at least GOOD_TICKS restarts the run of good cycles from zero.
- R7: Power-down is active when chipEnable is low or swPowerDown is high. It clears lockFlag, the good-cycle run and the error count at the next edge. Strobes are ignored while power-down is active.
- R8: When power-down is not active, lockFlag changes only at the clock edge that follows a cycleStrobe.
- R9: After reset, lockFlag is low and the error count and good-cycle run are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upPulse | input | 1 | Sampled raise pulse from the phase detector |
| dnPulse | input | 1 | Sampled lower pulse from the phase detector |
| cycleStrobe | input | 1 | One-tick marker closing each comparison cycle |
| precisionSel | input | 1 | 0: three good cycles to lock, 1: five |
| chipEnable | input | 1 | Low forces power-down |
| swPowerDown | input | 1 | High forces power-down |
| lockFlag | output | 1 | Active-high lock indication |

## Verification
The bench goes after the threshold edges:
- An error of 14 ticks counts toward lock and 15 ticks does not. A design with a `<=` compare would lock a cycle early.
- An error of 25 ticks keeps lock and 26 ticks drops it. An off-by-one compare would drop lock on 25.
- An error made of a raise pulse followed by a lower pulse has to add up to 16 ticks and break the run. A design that counts only one of the two pulses would lock too soon.
- An error of 265 ticks must saturate and release lock. A wrapping counter would read it as 9 ticks and stay locked.

Power-down is checked in three ways. It must clear a partial run, so that one good cycle after it does not complete a lock. It must block acquisition while it is held. It must drop lock whether it comes from the pin or from the bit.

// File: rtl/lock_watch_pkg.sv
package lock_watch_pkg;
  // Strobes issued by the control to the datapath each clock.
  typedef struct packed {
    logic clrWidth;
    logic clrRun;
    logic incRun;
  } ctlStrobes_t;
endpackage

// File: rtl/lock_watch_dp.sv
module lock_watch_dp
  import lock_watch_pkg::*;
#(
  parameter int ERR_BITS = 8,
  parameter int RUN_MAX  = 5,
  localparam int RUN_BITS = $clog2(RUN_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upPulse,
  input  logic                dnPulse,
  input  ctlStrobes_t         ctl,
  output logic [ERR_BITS-1:0] widthNow,
  output logic [RUN_BITS-1:0] runCount
);
  localparam logic [ERR_BITS-1:0] WIDTH_SAT = '1;
  localparam logic [RUN_BITS-1:0] RUN_TOP   = RUN_BITS'(RUN_MAX);

  logic [ERR_BITS-1:0] widthAcc;
  logic                sampleHigh;

  assign sampleHigh = upPulse | dnPulse;

  // The current edge's sample is included in the width, and the sum saturates.
  always_comb begin
    if (sampleHigh && widthAcc != WIDTH_SAT) widthNow = widthAcc + 1'b1;
    else                                     widthNow = widthAcc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            widthAcc <= '0;
    else if (ctl.clrWidth) widthAcc <= '0;
    else                   widthAcc <= widthNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              runCount <= '0;
    else if (ctl.clrRun)                     runCount <= '0;
    else if (ctl.incRun && runCount != RUN_TOP) runCount <= runCount + 1'b1;
  end

  // R1: the run never goes past its saturation value
  a_r1_run_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    runCount <= RUN_TOP);
  // R6: a clear request empties the run on the next edge
  a_r6_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clrRun |=> runCount == '0);
  // R1: a measured width never shrinks inside a window
  a_r1_width_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.clrWidth |=> widthNow >= $past(widthNow));
endmodule

// File: rtl/lock_watch_ctl.sv
module lock_watch_ctl
  import lock_watch_pkg::*;
#(
  parameter int ERR_BITS   = 8,
  parameter int GOOD_TICKS = 15,
  parameter int BAD_TICKS  = 25,
  parameter int RUN_SHORT  = 3,
  parameter int RUN_LONG   = 5,
  localparam int RUN_BITS  = $clog2(RUN_LONG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cycleStrobe,
  input  logic                precisionSel,
  input  logic                chipEnable,
  input  logic                swPowerDown,
  input  logic [ERR_BITS-1:0] widthNow,
  input  logic [RUN_BITS-1:0] runCount,
  output ctlStrobes_t         ctl,
  output logic                lockFlag
);
  logic isGood, isBad, pdActive, runReached, lockNext;
  logic [RUN_BITS:0] runNeed;

  assign pdActive   = !chipEnable || swPowerDown;
  assign isGood     = 32'(widthNow) <  GOOD_TICKS;
  assign isBad      = 32'(widthNow) >  BAD_TICKS;
  assign runNeed    = precisionSel ? (RUN_BITS+1)'(RUN_LONG) : (RUN_BITS+1)'(RUN_SHORT);
  assign runReached = ({1'b0, runCount} + 1'b1) >= runNeed;

  always_comb begin
    ctl      = '0;
    lockNext = lockFlag;
    if (pdActive) begin
      ctl.clrWidth = 1'b1;
      ctl.clrRun   = 1'b1;
      lockNext     = 1'b0;
    end else if (cycleStrobe) begin
      ctl.clrWidth = 1'b1;
      if (lockFlag) begin
        if (isBad) begin
          lockNext   = 1'b0;
          ctl.clrRun = 1'b1;
        end else if (isGood) begin
          ctl.incRun = 1'b1;
        end
      end else if (isGood) begin
        ctl.incRun = 1'b1;
        if (runReached) lockNext = 1'b1;
      end else begin
        ctl.clrRun = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lockFlag <= 1'b0;
    else        lockFlag <= lockNext;
  end

  // R7: power-down drops lock on the next edge
  a_r7_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pdActive |=> !lockFlag);
  // R8: without a strobe or power-down the flag holds
  a_r8_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycleStrobe && !pdActive) |=> $stable(lockFlag));
  // R4: a bad cycle releases lock
  a_r4_release_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (lockFlag && cycleStrobe && !pdActive && isBad) |=> !lockFlag);
  // R5: a cycle that is not bad keeps lock
  a_r5_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (lockFlag && cycleStrobe && !pdActive && !isBad) |=> lockFlag);
  // R2 / R3: lock rises only when the run has reached its required length
  a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockFlag) |-> ((32'($past(runCount)) + 1) >=
                         ($past(precisionSel) ? RUN_LONG : RUN_SHORT)));
endmodule

// File: rtl/lock_watch.sv
module lock_watch
  import lock_watch_pkg::*;
#(
  parameter int ERR_BITS   = 8,
  parameter int GOOD_TICKS = 15,
  parameter int BAD_TICKS  = 25,
  parameter int RUN_SHORT  = 3,
  parameter int RUN_LONG   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upPulse,
  input  logic dnPulse,
  input  logic cycleStrobe,
  input  logic precisionSel,
  input  logic chipEnable,
  input  logic swPowerDown,
  output logic lockFlag
);
  localparam int RUN_BITS = $clog2(RUN_LONG + 1);

  ctlStrobes_t         ctl;
  logic [ERR_BITS-1:0] widthNow;
  logic [RUN_BITS-1:0] runCount;

  lock_watch_dp #(.ERR_BITS(ERR_BITS), .RUN_MAX(RUN_LONG)) u_dp (
    .clk(clk), .rst_n(rst_n), .upPulse(upPulse), .dnPulse(dnPulse),
    .ctl(ctl), .widthNow(widthNow), .runCount(runCount)
  );

  lock_watch_ctl #(
    .ERR_BITS(ERR_BITS), .GOOD_TICKS(GOOD_TICKS), .BAD_TICKS(BAD_TICKS),
    .RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .cycleStrobe(cycleStrobe),
    .precisionSel(precisionSel), .chipEnable(chipEnable),
    .swPowerDown(swPowerDown), .widthNow(widthNow), .runCount(runCount),
    .ctl(ctl), .lockFlag(lockFlag)
  );
endmodule

// File: tb/lock_watch_test.sv
module lock_watch_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, upPulse, dnPulse, cycleStrobe, precisionSel, chipEnable, swPowerDown;
  logic lockFlag;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   stabChk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_watch uut (
    .clk(clk), .rst_n(rst_n), .upPulse(upPulse), .dnPulse(dnPulse),
    .cycleStrobe(cycleStrobe), .precisionSel(precisionSel),
    .chipEnable(chipEnable), .swPowerDown(swPowerDown), .lockFlag(lockFlag)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: lockFlag=%0b expected %0b", tag, got, exp);
    end
  endtask

  // One comparison cycle: upT ticks of raise pulse, then dnT ticks of lower pulse.
  // The strobe is on the last tick. Afterwards lockFlag holds the new decision.
  task automatic runCycle(input int upT, input int dnT);
    int   total;
    logic startVal;
    bit   moved;
    total = (upT + dnT + 2 > 40) ? upT + dnT + 2 : 40;
    moved = 1'b0;
    startVal = lockFlag;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (lockFlag !== startVal) moved = 1'b1;
      upPulse     = (i < upT);
      dnPulse     = (i >= upT) && (i < upT + dnT);
      cycleStrobe = (i == total - 1);
    end
    @(negedge clk);
    upPulse = 1'b0; dnPulse = 1'b0; cycleStrobe = 1'b0;
    if (stabChk) check(moved, 1'b0, "R8 flag moved inside window");
  endtask

  task automatic goodRun(input int n);
    for (int k = 0; k < n; k++) runCycle(5, 0);
  endtask

  task automatic doReset();
    rst_n = 1'b0; upPulse = 0; dnPulse = 0; cycleStrobe = 0;
    precisionSel = 0; chipEnable = 1; swPowerDown = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    doReset();
    check(lockFlag, 1'b0, "R9 reset state");
  endtask

  task automatic t_acquire3();
    doReset();
    stabChk = 1'b1;
    goodRun(2);
    check(lockFlag, 1'b0, "R2 two good cycles");
    runCycle(14, 0);
    check(lockFlag, 1'b1, "R2 third good cycle (14 ticks)");
    stabChk = 1'b0;
  endtask

  task automatic t_release();
    doReset();
    goodRun(3);
    runCycle(25, 0);
    check(lockFlag, 1'b1, "R5 error of 25 keeps lock");
    runCycle(0, 20);
    check(lockFlag, 1'b1, "R5 error of 20 keeps lock");
    runCycle(26, 0);
    check(lockFlag, 1'b0, "R4 error of 26 releases");
  endtask

  task automatic t_boundary();
    doReset();
    goodRun(2);
    runCycle(15, 0);
    check(lockFlag, 1'b0, "R6 error of 15 not good");
    goodRun(2);
    check(lockFlag, 1'b0, "R6 run restarted");
    goodRun(1);
    check(lockFlag, 1'b1, "R6 lock after fresh run");
  endtask

  task automatic t_split();
    doReset();
    goodRun(2);
    runCycle(10, 6);
    check(lockFlag, 1'b0, "R1 up+dn sum 16 breaks run");
    goodRun(2);
    check(lockFlag, 1'b0, "R1 run restarted after split error");
  endtask

  task automatic t_precision();
    doReset();
    precisionSel = 1'b1;
    goodRun(4);
    check(lockFlag, 1'b0, "R3 four good cycles");
    goodRun(1);
    check(lockFlag, 1'b1, "R3 fifth good cycle");
    precisionSel = 1'b0;
  endtask

  task automatic t_saturate();
    doReset();
    goodRun(3);
    runCycle(265, 0);
    check(lockFlag, 1'b0, "R1 265 ticks saturate and release");
  endtask

  task automatic t_powerdown();
    doReset();
    goodRun(3);
    @(negedge clk); swPowerDown = 1'b1;
    @(negedge clk); swPowerDown = 1'b0;
    check(lockFlag, 1'b0, "R7 register power-down clears lock");
    goodRun(2);
    @(negedge clk); chipEnable = 1'b0;
    @(negedge clk); chipEnable = 1'b1;
    goodRun(1);
    check(lockFlag, 1'b0, "R7 pin power-down cleared run");
    swPowerDown = 1'b1;
    goodRun(3);
    check(lockFlag, 1'b0, "R7 strobes ignored while down");
    swPowerDown = 1'b0;
    goodRun(3);
    check(lockFlag, 1'b1, "R7 relock after power-up");
    @(negedge clk); chipEnable = 1'b0;
    @(negedge clk);
    check(lockFlag, 1'b0, "R7 pin drops lock");
    chipEnable = 1'b1;
  endtask

  initial begin
    t_reset();
    t_acquire3();
    t_release();
    t_boundary();
    t_split();
    t_precision();
    t_saturate();
    t_powerdown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule